// File: doc/BRIEF.md
# Multiplexed Bus Cycle Generator

This block is the host end of an 8-bit multiplexed external bus. A fast system clock is divided down to a bus clock, E. Every E period is one bus cycle. The low half of the period is the address half and the high half is the data half. The upper address byte has a lane of its own and is held for the whole cycle. The lower address byte and the data byte share one lane. The lower byte is on that lane during the address half, and a short strobe marks it so that an external latch can capture it on the strobe's falling edge. During the data half the lane carries write data from the host, or it is released so that the addressed device can return read data.

A requester offers an access with a valid/ready handshake: address, direction and write data. The request is taken in the last clock of a cycle and runs in the next one. Read data is captured as E falls and is returned with a one-clock completion pulse. When nothing is offered, the block runs an idle cycle: the direction line reads high and the lane is not driven in the data half. The shared lane is split into separate out, in and enable signals, so a pad ring or a test model can resolve it.

Top module: `mxb_bus_master`

## Requirements
- R1: `bus_e` is low for HALF clocks and then high for HALF clocks (default 2 + 2), repeating from reset. One bus cycle is one E period.
- R2: During an accepted access, `bus_addr_hi` carries address bits 15..8 in every clock of the cycle.
- R3: `bus_as` is high in the first STB_LEN clocks of each cycle (default 1), only while `bus_e` is low, and low otherwise.
- R4: While `bus_e` is low, `bus_ad_oe` is 1 and `bus_ad_out` carries address bits 7..0 of the access, so the byte is still driven when `bus_as` falls.
- R5: `bus_rw` is 1 for a read and 0 for a write, and it holds that value for the whole cycle.
- R6: In a write cycle, while `bus_e` is high, `bus_ad_oe` is 1 and `bus_ad_out` carries the write data.
- R7: In a read cycle, `bus_ad_oe` is 0 while `bus_e` is high. The value on `bus_ad_in` at the falling edge of E appears on `rsp_rdata`. `rsp_done` is high for exactly the first clock of the following cycle after every accepted access. A write leaves `rsp_rdata` unchanged.
- R8: `req_ready` is 1 only in the last clock of a cycle. A request with `req_valid` high in that clock runs in the next cycle, whose first clock has `bus_as` high.
- R9: A cycle with no accepted request is idle: `bus_rw` is 1, `bus_ad_oe` is 0 while `bus_e` is high, and no `rsp_done` follows it.
- R10: An asynchronous reset (`rst_n` low) puts the block at the start of an idle cycle, with `bus_e` low, `bus_rw` 1, `rsp_done` 0, `rsp_rdata` 0 and `req_ready` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 2*HALF times the E rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access offered |
| req_ready | output | 1 | Offer taken this clock (last clock of a cycle) |
| req_addr | input | 16 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Last read data |
| bus_e | output | 1 | Bus clock E |
| bus_as | output | 1 | Address strobe |
| bus_rw | output | 1 | Direction, 1 = read |
| bus_addr_hi | output | 8 | Address bits 15..8 |
| bus_ad_out | output | 8 | Shared lane, driven value |
| bus_ad_in | input | 8 | Shared lane, received value |
| bus_ad_oe | output | 1 | Shared lane drive enable |

## Verification
The properties assume that the request fields are steady in the clock where `req_valid` and `req_ready` are both high, and that reset is released away from a clock edge. `bus_ad_in` may carry any value at any time, and only its value at the falling edge of E matters. The bench changes every input on the falling clock edge. It holds the request fields from the ready clock until the edge that takes them. It places the returned byte on `bus_ad_in` at the start of the data half and keeps it steady through the fall of E, so the capture never meets a changing input.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
   // Which half of the bus cycle the shared lane is in.
   typedef enum logic {
      HALF_ADDR = 1'b0,
      HALF_DATA = 1'b1
   } mxb_half_e;
endpackage

// File: rtl/mxb_phase_gen.sv
module mxb_phase_gen #(
   parameter int HALF    = 2,
   parameter int STB_LEN = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   output mxb_pkg::mxb_half_e half,
   output logic              strobe,
   output logic              last
);
   localparam int PERIOD = 2 * HALF;
   localparam int CW     = $clog2(PERIOD);
   localparam logic [CW-1:0] CNT_LAST = CW'(PERIOD - 1);
   localparam logic [CW-1:0] CNT_HALF = CW'(HALF);
   localparam logic [CW-1:0] CNT_STB  = CW'(STB_LEN);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (cnt == CNT_LAST) cnt <= '0;
      else                      cnt <= cnt + 1'b1;
   end

   assign half   = (cnt >= CNT_HALF) ? mxb_pkg::HALF_DATA : mxb_pkg::HALF_ADDR;
   assign strobe = (cnt < CNT_STB);
   assign last   = (cnt == CNT_LAST);
endmodule

// File: rtl/mxb_req_slot.sv
module mxb_req_slot #(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          req_valid,
   input  logic [AW-1:0] req_addr,
   input  logic          req_write,
   input  logic [DW-1:0] req_wdata,
   output logic          cyc_act,
   output logic          cyc_wr,
   output logic [AW-1:0] cyc_addr,
   output logic [DW-1:0] cyc_wdata
);
   // The slot changes only at a cycle boundary, so every bus field stays flat for a full E period.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_act   <= 1'b0;
         cyc_wr    <= 1'b0;
         cyc_addr  <= '0;
         cyc_wdata <= '0;
      end else if (load) begin
         cyc_act <= req_valid;
         cyc_wr  <= req_valid & req_write;
         if (req_valid) begin
            cyc_addr  <= req_addr;
            cyc_wdata <= req_wdata;
         end
      end
   end
endmodule

// File: rtl/mxb_rsp_cap.sv
module mxb_rsp_cap #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          e_fall,
   input  logic          cyc_act,
   input  logic          cyc_wr,
   input  logic [DW-1:0] lane_in,
   output logic          done,
   output logic [DW-1:0] rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done  <= 1'b0;
         rdata <= '0;
      end else begin
         done <= e_fall & cyc_act;
         if (e_fall && cyc_act && !cyc_wr) rdata <= lane_in;
      end
   end
endmodule

// File: rtl/mxb_lane_mux.sv
module mxb_lane_mux #(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  mxb_pkg::mxb_half_e half,
   input  logic              cyc_wr,
   input  logic [AW-1:0]     cyc_addr,
   input  logic [DW-1:0]     cyc_wdata,
   output logic [AW-DW-1:0]  addr_hi,
   output logic [DW-1:0]     lane_out,
   output logic              lane_oe
);
   localparam int HW = AW - DW;

   assign addr_hi = cyc_addr[AW-1 -: HW];

   // One generated multiplexer per lane bit: low address first, data second.
   for (genvar b = 0; b < DW; b++) begin : g_lane
      assign lane_out[b] = (half == mxb_pkg::HALF_DATA) ? cyc_wdata[b] : cyc_addr[b];
   end

   assign lane_oe = (half == mxb_pkg::HALF_ADDR) | cyc_wr;
endmodule

// File: rtl/mxb_bus_master.sv
module mxb_bus_master #(
   parameter int AW      = 16,
   parameter int DW      = 8,
   parameter int HALF    = 2,
   parameter int STB_LEN = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [AW-1:0]    req_addr,
   input  logic             req_write,
   input  logic [DW-1:0]    req_wdata,
   output logic             rsp_done,
   output logic [DW-1:0]    rsp_rdata,
   output logic             bus_e,
   output logic             bus_as,
   output logic             bus_rw,
   output logic [AW-DW-1:0] bus_addr_hi,
   output logic [DW-1:0]    bus_ad_out,
   input  logic [DW-1:0]    bus_ad_in,
   output logic             bus_ad_oe
);
   initial begin
      assert (HALF >= 2) else $error("HALF must be at least 2");
      assert (STB_LEN >= 1 && STB_LEN < HALF) else $error("STB_LEN must be 1..HALF-1");
      assert (AW > DW) else $error("AW must exceed DW");
   end

   mxb_pkg::mxb_half_e half;
   logic              strobe, last;
   logic              cyc_act, cyc_wr;
   logic [AW-1:0]     cyc_addr;
   logic [DW-1:0]     cyc_wdata;

   mxb_phase_gen #(.HALF(HALF), .STB_LEN(STB_LEN)) u_phase (
      .clk(clk), .rst_n(rst_n), .half(half), .strobe(strobe), .last(last)
   );

   mxb_req_slot #(.AW(AW), .DW(DW)) u_slot (
      .clk(clk), .rst_n(rst_n), .load(last),
      .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .req_wdata(req_wdata),
      .cyc_act(cyc_act), .cyc_wr(cyc_wr),
      .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata)
   );

   mxb_rsp_cap #(.DW(DW)) u_rsp (
      .clk(clk), .rst_n(rst_n), .e_fall(last),
      .cyc_act(cyc_act), .cyc_wr(cyc_wr), .lane_in(bus_ad_in),
      .done(rsp_done), .rdata(rsp_rdata)
   );

   mxb_lane_mux #(.AW(AW), .DW(DW)) u_mux (
      .half(half), .cyc_wr(cyc_wr), .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata),
      .addr_hi(bus_addr_hi), .lane_out(bus_ad_out), .lane_oe(bus_ad_oe)
   );

   assign req_ready = last;
   assign bus_e     = (half == mxb_pkg::HALF_DATA);
   assign bus_as    = strobe;
   assign bus_rw    = ~cyc_wr;
endmodule

// File: rtl/mxb_bus_chk.sv
module mxb_bus_chk #(
   parameter int HW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          rsp_done,
   input logic          bus_e,
   input logic          bus_as,
   input logic          bus_rw,
   input logic [HW-1:0] bus_addr_hi,
   input logic          bus_ad_oe
);
   assert_strobe_low_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_as |-> !bus_e);

   assert_lo_addr_at_strobe_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_as) |-> (!bus_e && bus_ad_oe));

   assert_hi_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_as |-> $stable(bus_addr_hi));

   assert_rw_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_as |-> $stable(bus_rw));

   assert_read_releases_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_e && bus_rw) |-> !bus_ad_oe);

   assert_write_drives_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_e && !bus_rw) |-> bus_ad_oe);

   assert_done_after_e_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> $fell(bus_e));

   assert_accept_starts_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> bus_as);
endmodule

bind mxb_bus_master mxb_bus_chk #(.HW(AW - DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .rsp_done(rsp_done), .bus_e(bus_e), .bus_as(bus_as), .bus_rw(bus_rw),
   .bus_addr_hi(bus_addr_hi), .bus_ad_oe(bus_ad_oe)
);

// File: tb/mxb_bus_master_bench.sv
module mxb_bus_master_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 8;
   // {valid, addr[15:0], write, wdata[7:0], returned byte[7:0]}
   localparam logic [33:0] VEC [NVEC] = '{
      {1'b1, 16'hA5C3, 1'b0, 8'h00, 8'h5A},
      {1'b1, 16'h4000, 1'b1, 8'h3C, 8'hFF},
      {1'b0, 16'h0000, 1'b0, 8'h00, 8'h77},
      {1'b1, 16'h5FFF, 1'b0, 8'h00, 8'h81},
      {1'b1, 16'hFFFF, 1'b1, 8'hFF, 8'h00},
      {1'b1, 16'h0000, 1'b0, 8'h00, 8'h00},
      {1'b1, 16'h1234, 1'b1, 8'hAA, 8'h55},
      {1'b0, 16'h0000, 1'b0, 8'h00, 8'h99}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic [7:0]  req_wdata = '0;
   logic        rsp_done;
   logic [7:0]  rsp_rdata;
   logic        bus_e, bus_as, bus_rw, bus_ad_oe;
   logic [7:0]  bus_addr_hi, bus_ad_out;
   logic [7:0]  bus_ad_in = '0;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   bit       pend_done = 0;
   bit       pend_rd = 0;
   logic [7:0] pend_data = '0;
   logic [7:0] last_rd = '0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   mxb_bus_master u_mxb_bus_master (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_write(req_write), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
      .bus_e(bus_e), .bus_as(bus_as), .bus_rw(bus_rw),
      .bus_addr_hi(bus_addr_hi), .bus_ad_out(bus_ad_out),
      .bus_ad_in(bus_ad_in), .bus_ad_oe(bus_ad_oe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // Called at the falling edge of the last clock of a cycle; runs one full cycle.
   task automatic run_cyc(input bit v, input logic [15:0] a, input bit w,
                          input logic [7:0] wd, input logic [7:0] ret);
      chk("R8 ready in last clock", req_ready, 1);
      req_valid = v; req_addr = a; req_write = w; req_wdata = wd;
      @(negedge clk);                                  // first clock
      req_valid = 1'b0;
      if (pend_done && pend_rd) last_rd = pend_data;
      chk("R7 done after access", rsp_done, pend_done);
      chk("R7 rdata", rsp_rdata, last_rd);
      chk("R3 strobe high", bus_as, 1);
      chk("R1 E low first half", bus_e, 0);
      chk("R8 ready low", req_ready, 0);
      chk("R4 lane enabled", bus_ad_oe, 1);
      if (v) begin
         chk("R2 high address", bus_addr_hi, a[15:8]);
         chk("R4 low address", bus_ad_out, a[7:0]);
         chk("R5 direction", bus_rw, !w);
      end else begin
         chk("R9 idle direction", bus_rw, 1);
      end
      @(negedge clk);                                  // second clock
      chk("R3 strobe one clock", bus_as, 0);
      chk("R1 E still low", bus_e, 0);
      chk("R7 done one clock", rsp_done, 0);
      chk("R4 lane enabled late", bus_ad_oe, 1);
      if (v) begin
         chk("R2 high address", bus_addr_hi, a[15:8]);
         chk("R4 low address late", bus_ad_out, a[7:0]);
         chk("R5 direction", bus_rw, !w);
      end
      @(negedge clk);                                  // third clock
      chk("R1 E high second half", bus_e, 1);
      chk("R3 strobe low", bus_as, 0);
      chk("R8 ready low", req_ready, 0);
      if (v && w) begin
         chk("R6 lane driven", bus_ad_oe, 1);
         chk("R6 write data", bus_ad_out, wd);
      end else if (v) begin
         chk("R7 lane released", bus_ad_oe, 0);
      end else begin
         chk("R9 idle lane released", bus_ad_oe, 0);
      end
      if (v) chk("R5 direction", bus_rw, !w);
      else   chk("R9 idle direction", bus_rw, 1);
      bus_ad_in = ret;
      @(negedge clk);                                  // last clock
      chk("R1 E high", bus_e, 1);
      if (v) begin
         chk("R2 high address", bus_addr_hi, a[15:8]);
         chk("R5 direction", bus_rw, !w);
      end
      pend_done = v;
      pend_rd   = v && !w;
      pend_data = ret;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 reset E", bus_e, 0);
      chk("R10 reset rw", bus_rw, 1);
      chk("R10 reset done", rsp_done, 0);
      chk("R10 reset rdata", rsp_rdata, 0);
      chk("R10 reset ready", req_ready, 0);
      rst_n = 1'b1;
      while (!req_ready) @(negedge clk);

      for (int i = 0; i < NVEC; i++)
         run_cyc(VEC[i][33], VEC[i][32:17], VEC[i][16], VEC[i][15:8], VEC[i][7:0]);
      run_cyc(1'b0, 16'h0, 1'b0, 8'h0, 8'h00);

      // Back-to-back read then write: the write must not alter the captured byte (R7).
      run_cyc(1'b1, 16'h2001, 1'b0, 8'h00, 8'hC7);
      run_cyc(1'b1, 16'h2002, 1'b1, 8'h11, 8'h3E);
      run_cyc(1'b0, 16'h0, 1'b0, 8'h0, 8'hE1);

      // Reset in the middle of a write cycle (R10).
      req_valid = 1'b1; req_addr = 16'h6789; req_write = 1'b1; req_wdata = 8'h42;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R10 mid-cycle reset rw", bus_rw, 1);
      chk("R10 mid-cycle reset E", bus_e, 0);
      chk("R10 mid-cycle reset rdata", rsp_rdata, 0);
      chk("R10 mid-cycle reset done", rsp_done, 0);
      @(negedge clk);
      rst_n = 1'b1;
      pend_done = 0; pend_rd = 0; last_rd = '0;
      while (!req_ready) @(negedge clk);
      run_cyc(1'b0, 16'h0, 1'b0, 8'h0, 8'h24);
      run_cyc(1'b1, 16'hBEEF, 1'b0, 8'h00, 8'h6D);
      run_cyc(1'b0, 16'h0, 1'b0, 8'h0, 8'h00);
      @(negedge clk);
      finish_run();
   end
endmodule